// File: doc/BRIEF.md
# Framed Serial PCM Port

This block connects a speech-processing core to a pair of 8-bit mu-law serial streams, one on the receive side and one on the send side. Both streams share an 8 kHz frame sync and a bit clock that may run anywhere from 64 to 2048 kHz. All logic runs on the system clock. The bit clock, the frame sync and both serial inputs pass through one common synchroniser. Edges of the bit clock are then found as single-cycle events.

Each frame, the port deserialises one byte per channel. It presents the two bytes in parallel and pulses a load-done strobe, which the core uses as its per-frame processing trigger. In the same frame, it serialises the two bytes the core returns. It asserts a drive-enable only while the eight data bits are on the line, and the pad tristate is controlled from that enable. An optional generator derives a bit clock and a frame sync from the system clock, for systems without an external codec timing source. With the defaults, an 18 MHz system clock yields 200 kHz and 8 kHz.

Top module: `pcm_serial_port`

## Requirements
- R1: Each channel carries 8 bits per frame, most significant bit first. The byte presented on `r_byte`/`s_byte` has bit 7 equal to the first data bit and bit 0 equal to the eighth.
- R2: Serial input bits are taken on the falling edge of the selected bit clock. A change of the input after that edge and before the next rising edge does not alter the captured byte.
- R3: `load_done` is a single system-clock pulse, issued once per complete frame after the eighth falling edge. `r_byte` and `s_byte` already hold the new bytes in the pulse cycle.
- R4: Frame sync is sampled on a falling bit-clock edge. The first data bit is the one sampled on the next falling edge after sync was seen high.
- R5: The serial outputs and `sdo_en` change only after a rising bit-clock edge. Bit 7 appears after the first rising edge that follows the falling edge on which sync was seen.
- R6: `sdo_en` is high for exactly the 8 bit periods of the outgoing byte and low otherwise. While it is low, `r_sdo` and `s_sdo` are 0.
- R7: If sync is seen again before 8 bits have been taken, the partial input byte is discarded and no `load_done` is issued for it. Output restarts at bit 7 of the bytes present at the new sync.
- R8: The generator outputs a bit clock with high and low phases of `HALF_DIV` system clocks. Its frame sync rises together with a bit-clock rising edge, stays high for one bit period, and repeats every `FRAME_BITS` bit periods. `use_int`=1 selects it in place of `bclk_in`/`fsync_in`.
- R9: While `pwr_down` is high, `gen_bclk` and `gen_fsync` stay low.
- R10: During reset, `r_byte`, `s_byte`, `load_done`, `sdo_en`, `r_sdo`, `s_sdo`, `gen_bclk` and `gen_fsync` are all 0.
- R11: The outgoing bytes are taken from `r_proc`/`s_proc` on the falling edge on which sync is seen. A later change of those inputs within the frame does not alter the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_int | input | 1 | 1 selects the internal bit clock and sync |
| pwr_down | input | 1 | Holds the internal generator stopped and low |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External 8 kHz frame sync |
| r_sdi | input | 1 | Receive-channel serial input |
| s_sdi | input | 1 | Send-channel serial input |
| gen_bclk | output | 1 | Internally generated bit clock |
| gen_fsync | output | 1 | Internally generated frame sync |
| r_byte | output | 8 | Last complete receive-channel byte |
| s_byte | output | 8 | Last complete send-channel byte |
| load_done | output | 1 | One-cycle pulse after both bytes are captured |
| r_proc | input | 8 | Processed receive-channel byte to transmit |
| s_proc | input | 8 | Processed send-channel byte to transmit |
| r_sdo | output | 1 | Receive-channel serial output |
| s_sdo | output | 1 | Send-channel serial output |
| sdo_en | output | 1 | Drive-enable for both serial output pads |

## Verification
The bench builds the port with `HALF_DIV`=3 and `FRAME_BITS`=12, so one generated frame spans only 72 system clocks. Several generated frames and their phase relation to the bit clock can therefore be measured clock by clock. The external bit clock is driven with 6-clock phases, which keeps the whole frame short. That makes an exhaustive sweep of all 256 values on each input channel affordable, with the send bytes varied alongside, the core bytes flipped mid-frame, and the input bits corrupted right after each falling edge. Interrupted frames and generator power-down are run as separate cases.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;
    localparam int PCM_BITS = 8;
    localparam int CNT_W    = $clog2(PCM_BITS + 1);
    typedef logic [PCM_BITS-1:0] pcm_byte_t;
    typedef logic [CNT_W-1:0]    pcm_cnt_t;
endpackage

// File: rtl/pcm_clk_gen.sv
`timescale 1ns/1ps
module pcm_clk_gen #(
    parameter int HALF_DIV   = 45,
    parameter int FRAME_BITS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic bclk,
    output logic fsync
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam int FB_W  = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
        logic [FB_W-1:0]  bit_idx;
        logic             fsync;
    } gen_t;

    gen_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pwr_down) begin
            s_d = '0;
        end else if (s_q.div == DIV_W'(HALF_DIV - 1)) begin
            s_d.div  = '0;
            s_d.bclk = ~s_q.bclk;
            if (!s_q.bclk) begin
                s_d.bit_idx = (s_q.bit_idx == FB_W'(FRAME_BITS - 1)) ? '0 : s_q.bit_idx + 1'b1;
                s_d.fsync   = (s_d.bit_idx == '0);
            end
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk  = s_q.bclk;
    assign fsync = s_q.fsync;

    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!bclk && !fsync));
    p_sync_with_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> $rose(bclk));
endmodule

// File: rtl/pcm_edge_sync.sv
`timescale 1ns/1ps
module pcm_edge_sync #(
    parameter int STAGES = 2,
    parameter int NDATA  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_a,
    input  logic             fsync_a,
    input  logic [NDATA-1:0] sdi_a,
    output logic             fsync_s,
    output logic [NDATA-1:0] sdi_s,
    output logic             rise,
    output logic             fall
);
    localparam int W = NDATA + 2;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic                     last;
    } sync_t;

    sync_t s_d, s_q;
    logic [W-1:0] tail;

    assign tail = s_q.chain[STAGES-1];

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = {sdi_a, fsync_a, bclk_a};
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.last = tail[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise    = tail[0] & ~s_q.last;
    assign fall    = ~tail[0] & s_q.last;
    assign fsync_s = tail[1];
    assign sdi_s   = tail[W-1:2];
endmodule

// File: rtl/pcm_rx_deser.sv
`timescale 1ns/1ps
module pcm_rx_deser
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fall,
    input  logic      fsync_s,
    input  logic      r_bit,
    input  logic      s_bit,
    output pcm_byte_t r_byte,
    output pcm_byte_t s_byte,
    output logic      load_done
);
    typedef struct packed {
        logic      active;
        pcm_cnt_t  cnt;
        pcm_byte_t sh_r;
        pcm_byte_t sh_s;
        pcm_byte_t out_r;
        pcm_byte_t out_s;
        logic      done;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (fall) begin
            if (fsync_s) begin
                s_d.active = 1'b1;
                s_d.cnt    = '0;
                s_d.sh_r   = '0;
                s_d.sh_s   = '0;
            end else if (s_q.active) begin
                s_d.sh_r = {s_q.sh_r[PCM_BITS-2:0], r_bit};
                s_d.sh_s = {s_q.sh_s[PCM_BITS-2:0], s_bit};
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == pcm_cnt_t'(PCM_BITS - 1)) begin
                    s_d.out_r  = s_d.sh_r;
                    s_d.out_s  = s_d.sh_s;
                    s_d.done   = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign r_byte    = s_q.out_r;
    assign s_byte    = s_q.out_s;
    assign load_done = s_q.done;

    p_done_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> $past(fall));
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);
endmodule

// File: rtl/pcm_tx_ser.sv
`timescale 1ns/1ps
module pcm_tx_ser
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise,
    input  logic      fall,
    input  logic      fsync_s,
    input  pcm_byte_t r_proc,
    input  pcm_byte_t s_proc,
    output logic      r_sdo,
    output logic      s_sdo,
    output logic      sdo_en
);
    typedef struct packed {
        logic      pend;
        pcm_cnt_t  cnt;
        pcm_byte_t sh_r;
        pcm_byte_t sh_s;
        logic      en;
        logic      bit_r;
        logic      bit_s;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fall && fsync_s) begin
            s_d.pend = 1'b1;
            s_d.sh_r = r_proc;
            s_d.sh_s = s_proc;
        end
        if (rise) begin
            if (s_q.pend || (s_q.en && s_q.cnt != pcm_cnt_t'(PCM_BITS))) begin
                s_d.en    = 1'b1;
                s_d.bit_r = s_q.sh_r[PCM_BITS-1];
                s_d.bit_s = s_q.sh_s[PCM_BITS-1];
                s_d.sh_r  = s_q.sh_r << 1;
                s_d.sh_s  = s_q.sh_s << 1;
                s_d.cnt   = s_q.pend ? pcm_cnt_t'(1) : s_q.cnt + 1'b1;
                s_d.pend  = 1'b0;
            end else if (s_q.en) begin
                s_d.en    = 1'b0;
                s_d.bit_r = 1'b0;
                s_d.bit_s = 1'b0;
                s_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign r_sdo  = s_q.bit_r;
    assign s_sdo  = s_q.bit_s;
    assign sdo_en = s_q.en;

    p_en_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_en) |-> $past(rise));
    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> (!r_sdo && !s_sdo));
endmodule

// File: rtl/pcm_serial_port.sv
`timescale 1ns/1ps
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int HALF_DIV    = 45,
    parameter int FRAME_BITS  = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_int,
    input  logic       pwr_down,
    input  logic       bclk_in,
    input  logic       fsync_in,
    input  logic       r_sdi,
    input  logic       s_sdi,
    output logic       gen_bclk,
    output logic       gen_fsync,
    output logic [7:0] r_byte,
    output logic [7:0] s_byte,
    output logic       load_done,
    input  logic [7:0] r_proc,
    input  logic [7:0] s_proc,
    output logic       r_sdo,
    output logic       s_sdo,
    output logic       sdo_en
);
    logic       bclk_sel, fsync_sel;
    logic       fsync_s, rise, fall;
    logic [1:0] sdi_s;

    pcm_clk_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_gen (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .bclk(gen_bclk), .fsync(gen_fsync)
    );

    assign bclk_sel  = use_int ? gen_bclk  : bclk_in;
    assign fsync_sel = use_int ? gen_fsync : fsync_in;

    pcm_edge_sync #(.STAGES(SYNC_STAGES), .NDATA(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bclk_a(bclk_sel), .fsync_a(fsync_sel), .sdi_a({s_sdi, r_sdi}),
        .fsync_s(fsync_s), .sdi_s(sdi_s), .rise(rise), .fall(fall)
    );

    pcm_rx_deser u_rx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .fsync_s(fsync_s),
        .r_bit(sdi_s[0]), .s_bit(sdi_s[1]),
        .r_byte(r_byte), .s_byte(s_byte), .load_done(load_done)
    );

    pcm_tx_ser u_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .fsync_s(fsync_s),
        .r_proc(r_proc), .s_proc(s_proc),
        .r_sdo(r_sdo), .s_sdo(s_sdo), .sdo_en(sdo_en)
    );
endmodule

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;
    localparam int HD = 3;
    localparam int FB = 12;
    localparam int HB = 6;

    logic clk = 0, rst_n = 0, use_int = 0, pwr_down = 0;
    logic bclk_in = 0, fsync_in = 0, r_sdi = 0, s_sdi = 0;
    logic gen_bclk, gen_fsync, load_done, r_sdo, s_sdo, sdo_en;
    logic [7:0] r_byte, s_byte, r_proc = 0, s_proc = 0;

    int checks = 0, errors = 0, done_cnt = 0;
    logic [7:0] cap_r = 0, cap_s = 0;
    bit fin = 0;

    always #10 clk = ~clk;

    pcm_serial_port #(.HALF_DIV(HD), .FRAME_BITS(FB), .SYNC_STAGES(2)) i_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .use_int(use_int), .pwr_down(pwr_down),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .r_sdi(r_sdi), .s_sdi(s_sdi),
        .gen_bclk(gen_bclk), .gen_fsync(gen_fsync), .r_byte(r_byte), .s_byte(s_byte),
        .load_done(load_done), .r_proc(r_proc), .s_proc(s_proc),
        .r_sdo(r_sdo), .s_sdo(s_sdo), .sdo_en(sdo_en)
    );

    always @(negedge clk) if (rst_n && load_done) begin
        done_cnt++;
        cap_r = r_byte;
        cap_s = s_byte;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit period: rise, hold, sample outputs, fall, then corrupt the inputs (R2)
    task automatic bitper(input logic sy, input logic dr, input logic ds,
                          output logic en_o, output logic ro, output logic so);
        @(negedge clk);
        bclk_in = 1; fsync_in = sy; r_sdi = dr; s_sdi = ds;
        repeat (HB - 1) @(negedge clk);
        en_o = sdo_en; ro = r_sdo; so = s_sdo;
        @(negedge clk);
        bclk_in = 0;
        repeat (3) @(negedge clk);
        r_sdi = ~dr; s_sdi = ~ds;
        repeat (HB - 3) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] ta, input logic [7:0] tb);
        logic e, ro, so;
        logic [7:0] got_r = 0, got_s = 0;
        bit en_all = 1;
        int base = done_cnt;
        r_proc = ta; s_proc = tb;
        bitper(1'b1, 1'b0, 1'b0, e, ro, so);
        for (int k = 1; k <= 8; k++) begin
            bitper(1'b0, a[8-k], b[8-k], e, ro, so);
            got_r = {got_r[6:0], ro};
            got_s = {got_s[6:0], so};
            if (!e) en_all = 0;
            if (k == 4) begin r_proc = ~ta; s_proc = ~tb; end   // R11 mid-frame change
        end
        bitper(1'b0, 1'b0, 1'b0, e, ro, so);
        chk(got_r == ta, "R5 R11 r_sdo byte", got_r, ta);
        chk(got_s == tb, "R1 R11 s_sdo byte", got_s, tb);
        chk(en_all, "R6 sdo_en during bits", en_all, 1);
        chk(!e && !ro && !so, "R6 idle quiet", {e, ro, so}, 0);
        chk(done_cnt == base + 1, "R3 one load_done", done_cnt - base, 1);
        chk(r_byte == a && s_byte == b, "R1 R2 R4 captured bytes", {r_byte, s_byte}, {a, b});
        chk(cap_r == a && cap_s == b, "R3 bytes at pulse", {cap_r, cap_s}, {a, b});
    endtask

    initial begin
        logic e, ro, so;
        int base0;
        // R10 reset state
        repeat (5) @(negedge clk);
        chk(r_byte == 0 && s_byte == 0, "R10 bytes", {r_byte, s_byte}, 0);
        chk(!load_done && !sdo_en && !r_sdo && !s_sdo, "R10 ctrl",
            {load_done, sdo_en, r_sdo, s_sdo}, 0);
        chk(!gen_bclk && !gen_fsync, "R10 gen", {gen_bclk, gen_fsync}, 0);
        rst_n = 1;

        // R8 generator timing
        begin
            logic pb = 0, ps = 0;
            int lbr = -1, lsr = -1, nb = 0, ns = 0;
            bit bad_p = 0, bad_w = 0, bad_sp = 0, bad_sw = 0;
            use_int = 1;
            for (int i = 0; i < HD * 2 * FB * 4; i++) begin
                @(negedge clk);
                if (gen_bclk && !pb) begin
                    if (lbr >= 0 && i - lbr != 2 * HD) bad_p = 1;
                    lbr = i; nb++;
                end
                if (!gen_bclk && pb && lbr >= 0 && i - lbr != HD) bad_w = 1;
                if (gen_fsync && !ps) begin
                    if (!(gen_bclk && !pb)) bad_sp = 1;
                    if (lsr >= 0 && i - lsr != 2 * HD * FB) bad_sp = 1;
                    lsr = i; ns++;
                end
                if (!gen_fsync && ps && lsr >= 0 && i - lsr != 2 * HD) bad_sw = 1;
                pb = gen_bclk; ps = gen_fsync;
            end
            chk(!bad_p && nb > 8, "R8 bclk period", nb, 2 * HD);
            chk(!bad_w, "R8 bclk high width", bad_w, 0);
            chk(!bad_sp && ns >= 3, "R8 sync period/phase", ns, 3);
            chk(!bad_sw, "R8 sync width", bad_sw, 0);
        end

        // R9 power-down
        begin
            bit seen = 0;
            pwr_down = 1;
            repeat (2) @(negedge clk);
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (gen_bclk || gen_fsync) seen = 1;
            end
            chk(!seen, "R9 generator held low", seen, 0);
            pwr_down = 0;
        end
        use_int = 0;
        repeat (10) @(negedge clk);

        // exhaustive sweep, R1 R2 R4 R5 R6 R11
        for (int v = 0; v < 256; v++) begin
            logic [7:0] bv;
            bv = 8'(v * 37 + 11);
            frame(8'(v), bv, 8'(v) ^ 8'h5A, ~8'(v));
        end

        // R7 interrupted frame: sync after 4 bits
        base0 = done_cnt;
        r_proc = 8'hFF; s_proc = 8'hFF;
        bitper(1'b1, 1'b0, 1'b0, e, ro, so);
        for (int k = 0; k < 4; k++) bitper(1'b0, 1'b1, 1'b0, e, ro, so);
        chk(done_cnt == base0, "R7 no pulse for partial", done_cnt - base0, 0);
        frame(8'h3C, 8'hC3, 8'h81, 8'h7E);
        chk(done_cnt == base0 + 1, "R7 only full frame counted", done_cnt - base0, 1);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule